// File: doc/BRIEF.md
# Dual Multi-Mode Look-Up Table Cell

The block holds two 16-bit look-up tables. Each table can be used as a 4-input logic function, as a small synchronous-write RAM, or as a serial shift register with a selectable tap. A 3-bit mode input chooses the behaviour of the pair. The two tables can also be fused into a 16x2 memory, a 32x1 memory, or a 16x1 memory with one write/read port and one read-only port. A configuration strobe loads both tables at once. Reads are always combinational. Writes, shifts and loads take effect only on a rising clock edge.

The block has no streaming interface. Every pin is plain control or data, sampled on the clock edge or read at once, so the block applies no back-pressure. A caller loads the tables, picks a mode, and then drives addresses and data. The outputs follow the addresses in the same cycle.

Top module: `lutp_top`

## Requirements
- R1: After an asynchronous reset (rst_n low), every bit of both tables is 0.
- R2: When cfg_load is high at a rising edge, table A takes cfg_a and table B takes cfg_b, whatever the mode and wr_en. The load overrides any write or shift in that cycle.
- R3: Mode 0 (logic) sets out_a = A[addr_a] and out_b = B[addr_b], combinationally. wr_en changes neither table.
- R4: Mode 1 (16x2 RAM) works as follows on a rising edge with wr_en high: A[addr_a] takes din_a and B[addr_a] takes din_b. The outputs are out_a = A[addr_a] and out_b = B[addr_a].
- R5: Mode 2 (32x1 RAM) uses addr_hi as the fifth address bit: 0 selects A and 1 selects B. On a rising edge with wr_en high, only the selected table is written, with din_a at addr_a. out_a is the selected table's bit at addr_a, and out_b is 0.
- R6: Mode 3 (dual-port RAM) works as follows on a rising edge with wr_en high: din_a is written at addr_a into both tables. The outputs are out_a = A[addr_a] and out_b = B[addr_b].
- R7: Mode 4 (shift) works as follows on a rising edge with wr_en high: in each table, bit 0 takes the serial input (din_a for A, din_b for B) and every other bit k takes the old bit k-1. The outputs are out_a = A[addr_a] and out_b = B[addr_b].
- R8: With wr_en low and cfg_load low, a rising edge leaves both tables unchanged in every mode.
- R9: Mode codes 5, 6 and 7 behave as mode 0. Reads follow R3 and no write or shift takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears both tables |
| mode | input | 3 | Behaviour select (codes in R3 to R9) |
| cfg_load | input | 1 | Load both tables from cfg_a / cfg_b |
| cfg_a | input | 16 | Load value for table A |
| cfg_b | input | 16 | Load value for table B |
| addr_a | input | 4 | Primary address / tap select |
| addr_b | input | 4 | Secondary read address / tap select |
| addr_hi | input | 1 | Fifth address bit in 32x1 mode |
| wr_en | input | 1 | Enables write or shift on the clock edge |
| din_a | input | 1 | Write data / serial input for A |
| din_b | input | 1 | Write data / serial input for B |
| out_a | output | 1 | Primary read data |
| out_b | output | 1 | Secondary read data |

## Verification
The bench drives a load together with an enabled shift. A design that orders these priorities wrongly would leave shifted contents in place of the configured pattern. In the 32x1 mode it writes the same address with both values of addr_hi. A design that decodes the fifth bit wrongly would corrupt the other table or read the wrong half. In dual-port mode it reads at an address different from the one being written. Writes with wr_en low, and writes under the unused mode codes, must leave the tables unchanged. A cell that ignores the enable would show flipped bits when both tables are read back. Shift taps are read at both ends of the register to catch an off-by-one in the shift direction.

// File: rtl/lutp_pkg.sv
package lutp_pkg;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef enum logic [2:0] {
    M_LOGIC = 3'd0,
    M_WIDE  = 3'd1,
    M_DEEP  = 3'd2,
    M_DUAL  = 3'd3,
    M_SHIFT = 3'd4
  } lutp_mode_e;
endpackage

// File: rtl/lutp_cell.sv
module lutp_cell #(
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic [(1<<ADDR_W)-1:0] load_val,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic                 wr_bit,
  input  logic                 sh_en,
  input  logic                 sh_in,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic                 rd_bit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mem <= '0;
    else if (load_en) mem <= load_val;
    else if (sh_en)   mem <= {mem[DEPTH-2:0], sh_in};
    else if (wr_en)   mem[wr_addr] <= wr_bit;
  end

  assign rd_bit = mem[rd_addr];

  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sh_en && !load_en) |=> mem[$past(wr_addr)] == $past(wr_bit));

  assert_shift_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_en && !load_en) |=> (mem[0] == $past(sh_in)) &&
                            (mem[DEPTH-1:1] == $past(mem[DEPTH-2:0])));

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !sh_en && !load_en) |=> $stable(mem));
endmodule

// File: rtl/lutp_ctrl.sv
module lutp_ctrl
  import lutp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       wr_en,
  input  logic       addr_hi,
  input  logic       din_a,
  input  logic       din_b,
  output logic [1:0] cell_we,
  output logic [1:0] cell_wd,
  output logic [1:0] cell_sh,
  output logic       b_reads_a,
  output logic       deep_mode
);
  always_comb begin
    cell_we   = 2'b00;
    cell_wd   = {din_b, din_a};
    cell_sh   = 2'b00;
    b_reads_a = 1'b0;
    deep_mode = 1'b0;
    case (mode)
      M_WIDE: begin
        cell_we   = {2{wr_en}};
        b_reads_a = 1'b1;
      end
      M_DEEP: begin
        cell_we   = wr_en ? (addr_hi ? 2'b10 : 2'b01) : 2'b00;
        cell_wd   = {din_a, din_a};
        b_reads_a = 1'b1;
        deep_mode = 1'b1;
      end
      M_DUAL: begin
        cell_we = {2{wr_en}};
        cell_wd = {din_a, din_a};
      end
      M_SHIFT: cell_sh = {2{wr_en}};
      default: ;
    endcase
  end

  assert_no_write_and_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !((|cell_we) && (|cell_sh)));

  assert_deep_one_cell_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DEEP) |-> $onehot0(cell_we));

  assert_no_action_without_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> (cell_we == 2'b00 && cell_sh == 2'b00));
endmodule

// File: rtl/lutp_top.sv
module lutp_top
  import lutp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              cfg_load,
  input  logic [DEPTH-1:0]  cfg_a,
  input  logic [DEPTH-1:0]  cfg_b,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic              addr_hi,
  input  logic              wr_en,
  input  logic              din_a,
  input  logic              din_b,
  output logic              out_a,
  output logic              out_b
);
  localparam int NCELL = 2;

  logic [1:0] cell_we, cell_wd, cell_sh;
  logic       b_reads_a, deep_mode;
  logic [NCELL-1:0] rd;
  logic [DEPTH-1:0] load_vals [NCELL];
  logic [ADDR_W-1:0] rd_addrs [NCELL];
  logic [NCELL-1:0] sh_ins;

  assign load_vals[0] = cfg_a;
  assign load_vals[1] = cfg_b;
  assign rd_addrs[0]  = addr_a;
  assign rd_addrs[1]  = b_reads_a ? addr_a : addr_b;
  assign sh_ins       = {din_b, din_a};

  lutp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .addr_hi(addr_hi),
    .din_a(din_a), .din_b(din_b), .cell_we(cell_we), .cell_wd(cell_wd),
    .cell_sh(cell_sh), .b_reads_a(b_reads_a), .deep_mode(deep_mode)
  );

  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    lutp_cell #(.ADDR_W(ADDR_W)) u_cell (
      .clk(clk), .rst_n(rst_n), .load_en(cfg_load), .load_val(load_vals[g]),
      .wr_en(cell_we[g]), .wr_addr(addr_a), .wr_bit(cell_wd[g]),
      .sh_en(cell_sh[g]), .sh_in(sh_ins[g]),
      .rd_addr(rd_addrs[g]), .rd_bit(rd[g])
    );
  end

  always_comb begin
    if (deep_mode) begin
      out_a = addr_hi ? rd[1] : rd[0];
      out_b = 1'b0;
    end else begin
      out_a = rd[0];
      out_b = rd[1];
    end
  end

  assert_deep_second_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DEEP) |-> (out_b == 1'b0));
endmodule

// File: tb/test_lutp_top.sv
module test_lutp_top;
  logic clk = 0, rst_n = 0;
  logic [2:0] mode = 0;
  logic cfg_load = 0;
  logic [15:0] cfg_a = 0, cfg_b = 0;
  logic [3:0] addr_a = 0, addr_b = 0;
  logic addr_hi = 0, wr_en = 0, din_a = 0, din_b = 0;
  logic out_a, out_b;

  logic [15:0] ma, mb;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lutp_top i_lutp_top (.*);

  task automatic chk(string req, logic got, logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (mode %0d aa %0d ab %0d hi %b)",
               req, got, exp, mode, addr_a, addr_b, addr_hi);
    end
  endtask

  // model update for the coming edge, then the edge
  task automatic edge1();
    logic [15:0] na = ma, nb = mb;
    if (cfg_load) begin na = cfg_a; nb = cfg_b; end
    else if (wr_en) begin
      case (mode)
        3'd1: begin na[addr_a] = din_a; nb[addr_a] = din_b; end
        3'd2: if (addr_hi) nb[addr_a] = din_a; else na[addr_a] = din_a;
        3'd3: begin na[addr_a] = din_a; nb[addr_a] = din_a; end
        3'd4: begin na = {ma[14:0], din_a}; nb = {mb[14:0], din_b}; end
        default: ;
      endcase
    end
    @(posedge clk); ma = na; mb = nb;
    @(negedge clk);
  endtask

  task automatic dump(string req);
    logic [2:0] sm = mode;
    mode = 3'd0;
    for (int i = 0; i < 16; i++) begin
      addr_a = i[3:0]; addr_b = 4'(15 - i); #1;
      chk(req, out_a, ma[i]); chk(req, out_b, mb[15 - i]);
    end
    mode = sm; #1;
  endtask

  task automatic t_reset();
    dump("R1");
  endtask

  task automatic t_load();
    cfg_a = 16'hA5C3; cfg_b = 16'h0F96; cfg_load = 1; mode = 3'd4; wr_en = 1; din_a = 1;
    edge1(); cfg_load = 0; wr_en = 0;
    dump("R2");
    chk("R2", ma == 16'hA5C3 ? 1'b1 : 1'b0, 1'b1);
  endtask

  task automatic t_logic();
    mode = 3'd0; wr_en = 1; din_a = 1; din_b = 1;
    for (int i = 0; i < 4; i++) begin addr_a = i[3:0]; edge1(); end
    wr_en = 0;
    dump("R3");
  endtask

  task automatic t_wide();
    mode = 3'd1; wr_en = 1;
    for (int i = 0; i < 6; i++) begin
      addr_a = 4'(i * 3); din_a = i[0]; din_b = ~i[1]; edge1();
    end
    wr_en = 0;
    for (int i = 0; i < 16; i++) begin
      addr_a = i[3:0]; addr_b = 4'(15 - i); #1;
      chk("R4", out_a, ma[i]); chk("R4", out_b, mb[i]);
    end
    dump("R4");
  endtask

  task automatic t_deep();
    mode = 3'd2; wr_en = 1;
    addr_a = 4'd5; addr_hi = 0; din_a = 0; edge1();
    addr_hi = 1; din_a = 1; edge1();
    addr_a = 4'd12; addr_hi = 1; din_a = 0; edge1();
    addr_hi = 0; din_a = 1; edge1();
    wr_en = 0;
    for (int i = 0; i < 32; i++) begin
      addr_a = i[3:0]; addr_hi = i[4]; addr_b = 4'd3; #1;
      chk("R5", out_a, i[4] ? mb[i[3:0]] : ma[i[3:0]]);
      chk("R5", out_b, 1'b0);
    end
    addr_hi = 0;
    dump("R5");
  endtask

  task automatic t_dual();
    mode = 3'd3; wr_en = 1;
    addr_a = 4'd2; din_a = 1; din_b = 0; edge1();
    addr_a = 4'd9; din_a = 0; edge1();
    addr_a = 4'd14; din_a = 1; edge1();
    wr_en = 0;
    for (int i = 0; i < 16; i++) begin
      addr_a = 4'd9; addr_b = i[3:0]; #1;
      chk("R6", out_a, ma[9]); chk("R6", out_b, mb[i]);
    end
    dump("R6");
  endtask

  task automatic t_shift();
    logic [15:0] pat = 16'hC3A1;
    mode = 3'd4; wr_en = 1;
    for (int i = 0; i < 20; i++) begin
      din_a = pat[i % 16]; din_b = ~pat[i % 16]; edge1();
      addr_a = 4'd0; addr_b = 4'd15; #1;
      chk("R7", out_a, ma[0]); chk("R7", out_b, mb[15]);
      addr_a = 4'd15; addr_b = 4'd1; #1;
      chk("R7", out_a, ma[15]); chk("R7", out_b, mb[1]);
    end
    wr_en = 0;
    dump("R7");
  endtask

  task automatic t_hold();
    wr_en = 0; din_a = 1; din_b = 1;
    for (int m = 1; m < 5; m++) begin
      mode = 3'(m);
      for (int i = 0; i < 3; i++) begin addr_a = 4'(i); addr_hi = i[0]; edge1(); end
      dump("R8");
    end
    addr_hi = 0;
  endtask

  task automatic t_unused();
    for (int m = 5; m < 8; m++) begin
      mode = 3'(m); wr_en = 1; din_a = ~ma[7]; din_b = ~mb[7]; addr_a = 4'd7;
      edge1(); wr_en = 0;
      for (int i = 0; i < 16; i++) begin
        addr_a = i[3:0]; addr_b = 4'(i ^ 5); #1;
        chk("R9", out_a, ma[i]); chk("R9", out_b, mb[i ^ 5]);
      end
    end
  endtask

  initial begin
    ma = '0; mb = '0;
    #10; @(negedge clk); rst_n = 1;
    t_reset(); t_load(); t_logic(); t_wide(); t_deep();
    t_dual(); t_shift(); t_hold(); t_unused();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule